// File: doc/BRIEF.md
# Four-Way Replacement Victim Selector

This block decides which way of a set-associative cache set receives a newly allocated line. Each cycle, the lookup logic presents the valid bits of the indexed set. The block returns a victim way in the same cycle, with no register between inputs and output. If the set has an empty way, the lowest-numbered empty way is chosen. If every eligible way is full, a single replacement pointer shared by all sets supplies the choice.

The allocate strobe tells the block that the caller has committed to the presented victim. The pointer moves on only when the committed victim came from the pointer. Filling an empty way leaves the pointer where it is.

A half-lock input protects the lower ways (ways 0 and 1 by default). While it is high, neither the empty-way search nor the pointer ever returns a protected way. The pointer then alternates between the two upper ways. If the pointer holds a protected index when the lock is raised, it is read as way 2.

Top module: `victim_select`

## Requirements
- R1: While reset is low and after reset is released, the pointer holds way 0. With all four ways valid, no lock and no allocate, the victim is 0.
- R2: Without the lock, if any valid bit is 0, the victim is the lowest-numbered way whose valid bit is 0. Bit i of the valid vector is way i, and way 0 has the highest priority.
- R3: Without the lock and with all four valid bits set, the victim equals the pointer.
- R4: An allocate strobe sampled on a rising clock edge while the victim comes from the pointer advances the pointer by one way. Way 3 wraps to way 0 when the lock is off.
- R5: An allocate strobe while the victim is an empty way leaves the pointer unchanged.
- R6: With the lock on, empty ways 0 and 1 are ignored. The victim is the lower of ways 2 and 3 that is empty. If both are valid, the victim comes from the pointer.
- R7: With the lock on, a victim taken from the pointer is always 2 or 3. Successive pointer allocations alternate between 2 and 3.
- R8: If the lock is on while the pointer holds 0 or 1, the pointer victim is 2. An allocate then moves the pointer to 3.
- R9: With no allocate strobe, the pointer keeps its value.
- R10: The victim output is combinational. It reflects changed valid bits or a changed lock in the same cycle, before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| way_valid | input | 4 | Valid bits of the indexed set; bit i is way i |
| alloc | input | 1 | Caller commits an allocation to the presented victim |
| half_lock | input | 1 | Protects ways 0 and 1 from selection |
| victim_way | output | 2 | Chosen way, combinational |

## Verification
The only internal state is the replacement pointer, so any corruption shows up at `victim_way` the first time a set is full. A skipped or doubled advance, a wrong wrap point, or an advance on an empty-way fill moves every later pointer choice by one way. The bench's reference model flags this on the first full-set cycle after the error. Errors in the priority or lock masking are purely combinational, so they show up in the very cycle that presents the offending valid pattern.

// File: rtl/victim_sel_pkg.sv
package victim_sel_pkg;
   // Origin of the victim presented this cycle.
   typedef enum logic {
      SRC_FREE = 1'b0,
      SRC_PTR  = 1'b1
   } victim_src_e;

   // True when n is a power of two and at least 2.
   function automatic bit is_pow2(input int unsigned n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/vs_first_free.sv
module vs_first_free #(
   parameter int unsigned WAYS = 4,
   localparam int unsigned IW  = $clog2(WAYS)
) (
   input  logic [WAYS-1:0] cand,
   output logic            any,
   output logic [IW-1:0]   idx
);
   // Lowest set bit wins; scan from the top so the lowest index is written last.
   always_comb begin
      any = |cand;
      idx = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (cand[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/vs_repl_ptr.sv
module vs_repl_ptr #(
   parameter int unsigned WAYS      = 4,
   parameter int unsigned LOCK_WAYS = 2,
   localparam int unsigned IW       = $clog2(WAYS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lock,
   input  logic          advance,
   output logic [IW-1:0] cur
);
   logic [IW-1:0] ptr_q;
   logic [IW-1:0] cur_c;
   logic [IW-1:0] nxt_c;

   generate
      if (LOCK_WAYS == 0) begin : g_unconfined
         // No protected ways: plain modulo counter.
         assign cur_c = ptr_q;
         assign nxt_c = ptr_q + 1'b1;
      end else begin : g_confined
         localparam logic [IW-1:0] BASE = IW'(LOCK_WAYS);
         localparam logic [IW-1:0] TOP  = IW'(WAYS - 1);
         always_comb begin
            cur_c = ptr_q;
            if (lock && (ptr_q < BASE)) cur_c = BASE;
            if (cur_c == TOP) nxt_c = lock ? BASE : '0;
            else              nxt_c = cur_c + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (advance) ptr_q <= nxt_c;
   end

   assign cur = cur_c;

   // R9 / R5: the pointer moves only on a committed pointer allocation
   assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(ptr_q));
endmodule

// File: rtl/victim_select.sv
module victim_select #(
   parameter int unsigned WAYS      = 4,
   parameter int unsigned LOCK_WAYS = 2,
   localparam int unsigned IW       = $clog2(WAYS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [WAYS-1:0] way_valid,
   input  logic            alloc,
   input  logic            half_lock,
   output logic [IW-1:0]   victim_way
);
   import victim_sel_pkg::*;

   localparam logic [IW-1:0] BASE = IW'(LOCK_WAYS);

   generate
      if (!is_pow2(WAYS)) begin : g_bad_ways
         $error("victim_select: WAYS must be a power of two, at least 2");
      end
      if (LOCK_WAYS >= WAYS) begin : g_bad_lock
         $error("victim_select: LOCK_WAYS must leave at least one way open");
      end
   endgenerate

   logic [WAYS-1:0] eligible;
   logic            free_any;
   logic [IW-1:0]   free_idx;
   logic [IW-1:0]   ptr_cur;
   victim_src_e     src;
   logic            advance;

   // Per-way eligibility: empty, and not protected while locked.
   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_elig
         if (w < LOCK_WAYS) begin : g_prot
            assign eligible[w] = !way_valid[w] && !half_lock;
         end else begin : g_open
            assign eligible[w] = !way_valid[w];
         end
      end
   endgenerate

   vs_first_free #(.WAYS(WAYS)) u_free (
      .cand (eligible),
      .any  (free_any),
      .idx  (free_idx)
   );

   vs_repl_ptr #(.WAYS(WAYS), .LOCK_WAYS(LOCK_WAYS)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock    (half_lock),
      .advance (advance),
      .cur     (ptr_cur)
   );

   assign src        = free_any ? SRC_FREE : SRC_PTR;
   assign advance    = alloc && (src == SRC_PTR);
   assign victim_way = (src == SRC_FREE) ? free_idx : ptr_cur;

   // R2: with no lock, an empty way is always chosen over the pointer
   assert_empty_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!half_lock && !(&way_valid)) |-> !way_valid[victim_way]);

   // R6: with the lock on, an empty upper way is chosen and lower ways never are
   assert_lock_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (half_lock && !(&way_valid[WAYS-1:LOCK_WAYS]))
         |-> (victim_way >= BASE && !way_valid[victim_way]));

   // R7: a locked victim never lands in a protected way
   assert_lock_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      half_lock |-> victim_way >= BASE);

   // R4: consecutive full-set unlocked allocations step by one way
   assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc && (&way_valid) && !half_lock)
         |=> (!((&way_valid) && !half_lock) || victim_way == IW'($past(victim_way) + 1'b1)));

   // R7: consecutive full-set locked allocations alternate
   assert_lock_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc && (&way_valid) && half_lock)
         |=> (!((&way_valid) && half_lock) || victim_way != $past(victim_way)));
endmodule

// File: tb/victim_select_test.sv
`timescale 1ns/100ps
module victim_select_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] way_valid = 4'hF;
   logic       alloc = 1'b0;
   logic       half_lock = 1'b0;
   logic [1:0] victim_way;

   int compared = 0;
   int mismatched = 0;
   int mptr = 0;   // reference replacement pointer
   bit finished = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   victim_select uut (
      .clk(clk), .rst_n(rst_n), .way_valid(way_valid),
      .alloc(alloc), .half_lock(half_lock), .victim_way(victim_way)
   );

   // Behavioural expectation straight from the requirements.
   function automatic int ref_victim(input logic [3:0] v, input logic lk,
                                     input int p, output bit from_ptr);
      for (int i = 0; i < 4; i++) begin
         if (!v[i] && !(lk && i < 2)) begin
            from_ptr = 0;
            return i;
         end
      end
      from_ptr = 1;
      if (lk && p < 2) return 2;
      return p;
   endfunction

   function automatic int ref_next(input int e, input logic lk);
      if (lk) return (e == 3) ? 2 : e + 1;
      return (e + 1) % 4;
   endfunction

   task automatic compare(input int exp, input string tag);
      compared++;
      if (int'(victim_way) != exp) begin
         mismatched++;
         $display("FAIL %s: victim_way=%0d expected=%0d (valid=%b lock=%b alloc=%b)",
                  tag, victim_way, exp, way_valid, half_lock, alloc);
      end
   endtask

   // Drive one cycle of stimulus, check the same-cycle victim, update the model.
   task automatic step(input logic [3:0] v, input logic a, input logic lk, input string tag);
      bit fp;
      int e;
      @(negedge clk);
      way_valid = v; alloc = a; half_lock = lk;
      #1;
      e = ref_victim(v, lk, mptr, fp);
      compare(e, tag);
      if (a && fp) mptr = ref_next(e, lk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      #1;
      compare(0, "R1 during reset");
      @(negedge clk);
      rst_n = 1'b1;
      mptr = 0;

      step(4'hF, 0, 0, "R1 after reset");
      // R2 priority patterns
      step(4'b1110, 0, 0, "R2 way0 empty");
      step(4'b1101, 0, 0, "R2 way1 empty");
      step(4'b1011, 0, 0, "R2 way2 empty");
      step(4'b0111, 0, 0, "R2 way3 empty");
      step(4'b0000, 0, 0, "R2 all empty");
      step(4'b1010, 0, 0, "R2 ways0,2 empty");
      // R5 fill of an empty way keeps the pointer
      step(4'b1011, 1, 0, "R5 fill empty");
      step(4'hF,    0, 0, "R5 pointer kept");
      step(4'hF,    0, 0, "R9 idle hold");
      // R3 / R4 pointer stepping and wrap
      step(4'hF, 1, 0, "R3 ptr0");
      step(4'hF, 1, 0, "R4 ptr1");
      step(4'hF, 1, 0, "R4 ptr2");
      step(4'hF, 1, 0, "R4 ptr3");
      step(4'hF, 1, 0, "R4 wrap0");
      step(4'hF, 0, 0, "R9 hold after wrap");
      // R8 lock raised while pointer is 1
      step(4'hF, 0, 1, "R8 forced way2");
      step(4'hF, 1, 1, "R8 alloc from forced");
      step(4'hF, 1, 1, "R7 alt 3");
      step(4'hF, 1, 1, "R7 alt 2");
      step(4'hF, 1, 1, "R7 alt 3 again");
      // R6 lock masks lower empty ways
      step(4'b1100, 0, 1, "R6 lower empty ignored");
      step(4'b1011, 0, 1, "R6 way2 empty");
      step(4'b0111, 0, 1, "R6 way3 empty");
      step(4'b0000, 1, 1, "R6 all empty locked");
      step(4'hF,    0, 0, "R10 unlock same cycle");
      step(4'b1110, 0, 0, "R10 valid change same cycle");

      for (int n = 0; n < 3000; n++) begin
         logic [3:0] v;
         v = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'hF;
         step(v, 1'($urandom), ($urandom_range(0, 3) == 0), "R10 random");
      end

      finished = 1;
      summary();
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog R10: run incomplete, actual=hung expected=done");
         summary();
         $finish;
      end
   end
endmodule